// File: doc/BRIEF.md
# LCD Controller Low-Power Mode Manager

This block puts a small display controller into a low-power state, brings it out again, and does both under software control. A control register on the register bus holds the enable bit. Software sets the bit to enter the low-power state and clears it to leave. The same register also holds a read-only flag that shows whether the display-buffer memory controller is powered down at that moment. The controller leaves reset already in the low-power state. Software loads its registers and then clears the enable bit to start the display.

In the low-power state, the frame refresh scan stops and makes no buffer reads. The panel data, enable and frame-sync outputs are held low, and the PWM clock output stops. The host can still write to the display buffer: for each write the memory controller is woken, the write is done, and the controller goes back to sleep once the bus is idle. The buffer refuses host reads while the state lasts. A refused read still completes its handshake, so the bus never stalls. The lookup-table registers and the general-purpose pin register stay readable and writable in both states.

A strap input is captured when reset is released. It decides whether the multi-purpose pins carry panel-control signals, which go low in the low-power state, or mirror a software-written GPIO register, which is never forced. The refresh scan, the buffer array and the PWM divider are small stand-in models.

Top module: `lcd_pwrsave_mgr`

## Requirements
- R1: After reset the control register at address A0h reads 09h: bit 0 (low-power enable) is 1 and bit 3 (memory controller asleep) is 1. Panel outputs, PWM clock and bus acknowledge are 0.
- R2: At A0h, bit 0 can be written and read back. Bit 3 ignores writes and all other bits read 0.
- R3: In the low-power state, bit 3 reads 0 in the cycle after a buffer write request is sampled while the controller sleeps. It reads 1 again one clock after the acknowledge cycle ends, if no further request is present.
- R4: In the low-power state, a buffer write is acknowledged one cycle after the controller wakes. The written data is later seen in normal-mode reads and on the panel.
- R5: In the low-power state, a buffer read is acknowledged one cycle after the request with all-zero data, and it does not wake the controller.
- R6: In normal mode, a buffer access is acknowledged for exactly one cycle, one cycle after the request, and reads return the stored word.
- R7: One cycle after the low-power state begins, panel data and panel enable are 0 and the PWM clock is 0. They stay there while the state lasts.
- R8: After the enable bit is cleared, the first panel word is buffer address 0 with frame sync high. The following cycles present consecutive addresses, wrapping at the buffer depth.
- R9: In normal mode the PWM clock starts low and toggles every PWM_DIV cycles.
- R10: Lookup-table registers (addresses below LUT_DEPTH) and the GPIO register at A8h are writable and readable in both states.
- R11: The strap value at reset release selects the pin role. 1 means each pin drives its GPIO register bit, in both states. 0 means even pins drive panel enable and odd pins drive frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; strap captured on its rising edge |
| cfg_strap | input | 1 | Pin-role strap (1 = GPIO role) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational from reg_addr) |
| mem_req | input | 1 | Buffer access request, held until acknowledged |
| mem_we | input | 1 | Buffer access is a write |
| mem_addr | input | MEM_AW | Buffer word address |
| mem_wdata | input | DATA_W | Buffer write data |
| mem_ack | output | 1 | One-cycle access acknowledge |
| mem_rdata | output | DATA_W | Buffer read data, valid with mem_ack |
| lcd_data | output | DATA_W | Panel pixel word |
| lcd_den | output | 1 | Panel data enable |
| lcd_fsync | output | 1 | Panel frame sync (first word of a frame) |
| pwm_clk | output | 1 | PWM clock output |
| gpio_pins | output | GPIO_W | Multi-purpose pins |

## Verification
Suppose the power-state register or the wake flag is wrong. Bit 3 of the register at A0h then differs in the next cycle, and the acknowledge timing of a low-power write moves by a cycle. A scan pointer that is not parked during the low-power state shows up in the first panel word after the exit: it is not address 0, or it lacks frame sync. A divider that is not cleared shows up as a shifted PWM edge within PWM_DIV cycles. A wrong strap capture shows up on the pins in the first cycle after reset.

// File: rtl/lcd_pwrsave_pkg.sv
package lcd_pwrsave_pkg;
   // bit positions inside the control register (decoded by software)
   localparam int unsigned PS_EN_BIT   = 0;
   localparam int unsigned PS_STAT_BIT = 3;

   // kind of buffer access granted in a cycle
   typedef enum logic [1:0] {
      ACC_NONE   = 2'd0,
      ACC_WR     = 2'd1,
      ACC_RD     = 2'd2,
      ACC_RD_NO  = 2'd3
   } acc_e;
endpackage

// File: rtl/lcd_pwrsave_regs.sv
module lcd_pwrsave_regs
   import lcd_pwrsave_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned REG_AW    = 8,
   parameter int unsigned GPIO_W    = 4,
   parameter int unsigned LUT_DEPTH = 16,
   parameter int unsigned CTRL_ADDR = 'hA0,
   parameter int unsigned GPIO_ADDR = 'hA8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              mc_asleep,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              ps_en,
   output logic [GPIO_W-1:0] gpio_q,
   output logic              gpio_role
);
   localparam int unsigned LUT_IW = (LUT_DEPTH > 1) ? $clog2(LUT_DEPTH) : 1;

   if (DATA_W <= PS_STAT_BIT) begin : g_bad_dw
      $error("DATA_W too narrow for the status bit");
   end
   if (GPIO_W > DATA_W || GPIO_W == 0) begin : g_bad_gw
      $error("GPIO_W must be 1..DATA_W");
   end
   if ((LUT_DEPTH & (LUT_DEPTH - 1)) != 0 || LUT_DEPTH > CTRL_ADDR || LUT_DEPTH > GPIO_ADDR) begin : g_bad_lut
      $error("LUT_DEPTH must be a power of two below the control addresses");
   end
   if (CTRL_ADDR >= (1 << REG_AW) || GPIO_ADDR >= (1 << REG_AW) || CTRL_ADDR == GPIO_ADDR) begin : g_bad_addr
      $error("register addresses out of range or overlapping");
   end

   logic              hit_ctrl, hit_gpio, hit_lut;
   logic [LUT_IW-1:0] lut_idx;
   logic [DATA_W-1:0] lut_q [LUT_DEPTH];

   assign hit_ctrl = (reg_addr == REG_AW'(CTRL_ADDR));
   assign hit_gpio = (reg_addr == REG_AW'(GPIO_ADDR));
   assign hit_lut  = (reg_addr <  REG_AW'(LUT_DEPTH));
   assign lut_idx  = reg_addr[LUT_IW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ps_en  <= 1'b1;
         gpio_q <= '0;
         for (int i = 0; i < LUT_DEPTH; i++) lut_q[i] <= '0;
      end else if (reg_wr) begin
         if (hit_ctrl) ps_en <= reg_wdata[PS_EN_BIT];
         if (hit_gpio) gpio_q <= reg_wdata[GPIO_W-1:0];
         if (hit_lut)  lut_q[lut_idx] <= reg_wdata;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (hit_ctrl) begin
         reg_rdata[PS_EN_BIT]   = ps_en;
         reg_rdata[PS_STAT_BIT] = mc_asleep;
      end else if (hit_gpio) begin
         reg_rdata[GPIO_W-1:0] = gpio_q;
      end else if (hit_lut) begin
         reg_rdata = lut_q[lut_idx];
      end
   end

   // pin role strap: captured on reset release
   always_ff @(posedge rst_n) gpio_role <= strap;
endmodule

// File: rtl/lcd_pwrsave_bufctl.sv
module lcd_pwrsave_bufctl
   import lcd_pwrsave_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned MEM_AW = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ps_en,
   input  logic              mem_req,
   input  logic              mem_we,
   input  logic [MEM_AW-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_wdata,
   output logic              mem_ack,
   output logic [DATA_W-1:0] mem_rdata,
   output logic              mc_asleep,
   input  logic [MEM_AW-1:0] scan_addr,
   output logic [DATA_W-1:0] scan_data
);
   localparam int unsigned MEM_DEPTH = 1 << MEM_AW;

   if (MEM_AW == 0 || MEM_AW > 12) begin : g_bad_aw
      $error("MEM_AW must be 1..12");
   end

   logic              awake_q, ack_q, pend;
   logic [DATA_W-1:0] rdata_q;
   logic [DATA_W-1:0] ram [MEM_DEPTH];
   acc_e              acc;

   assign pend = mem_req && !ack_q;

   always_comb begin
      acc = ACC_NONE;
      if (pend) begin
         if (mem_we) begin
            if (awake_q) acc = ACC_WR;
         end else if (ps_en) begin
            acc = ACC_RD_NO;
         end else if (awake_q) begin
            acc = ACC_RD;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         awake_q <= 1'b0;
         ack_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         ack_q   <= (acc != ACC_NONE);
         rdata_q <= (acc == ACC_RD) ? ram[mem_addr] : '0;
         if (!ps_en)
            awake_q <= 1'b1;
         else if (!awake_q && pend && mem_we)
            awake_q <= 1'b1;
         else if (awake_q && !mem_req && !ack_q)
            awake_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (acc == ACC_WR) ram[mem_addr] <= mem_wdata;
   end

   assign scan_data = ram[scan_addr];
   assign mem_ack   = ack_q;
   assign mem_rdata = rdata_q;
   assign mc_asleep = !awake_q;
endmodule

// File: rtl/lcd_pwrsave_panel.sv
module lcd_pwrsave_panel #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned MEM_AW  = 6,
   parameter int unsigned GPIO_W  = 4,
   parameter int unsigned PWM_DIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ps_en,
   input  logic [DATA_W-1:0] scan_data,
   output logic [MEM_AW-1:0] scan_addr,
   output logic [DATA_W-1:0] lcd_data,
   output logic              lcd_den,
   output logic              lcd_fsync,
   output logic              pwm_clk,
   input  logic              gpio_role,
   input  logic [GPIO_W-1:0] gpio_q,
   output logic [GPIO_W-1:0] gpio_pins
);
   if (PWM_DIV == 0) begin : g_bad_div
      $error("PWM_DIV must be at least 1");
   end

   // refresh scan: parked at frame top while in low power
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scan_addr <= '0;
         lcd_data  <= '0;
         lcd_den   <= 1'b0;
         lcd_fsync <= 1'b0;
      end else if (ps_en) begin
         scan_addr <= '0;
         lcd_data  <= '0;
         lcd_den   <= 1'b0;
         lcd_fsync <= 1'b0;
      end else begin
         lcd_data  <= scan_data;
         lcd_den   <= 1'b1;
         lcd_fsync <= (scan_addr == '0);
         scan_addr <= scan_addr + MEM_AW'(1);
      end
   end

   if (PWM_DIV == 1) begin : g_pwm_fast
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     pwm_clk <= 1'b0;
         else if (ps_en) pwm_clk <= 1'b0;
         else            pwm_clk <= !pwm_clk;
      end
   end else begin : g_pwm_div
      localparam int unsigned CW = $clog2(PWM_DIV);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n || ps_en) begin
            cnt     <= '0;
            pwm_clk <= 1'b0;
         end else if (cnt == CW'(PWM_DIV - 1)) begin
            cnt     <= '0;
            pwm_clk <= !pwm_clk;
         end else begin
            cnt <= cnt + CW'(1);
         end
      end
   end

   for (genvar i = 0; i < GPIO_W; i++) begin : g_pin
      logic panel_bit;
      if (i % 2 == 0) begin : g_even
         assign panel_bit = lcd_den;
      end else begin : g_odd
         assign panel_bit = lcd_fsync;
      end
      assign gpio_pins[i] = gpio_role ? gpio_q[i] : panel_bit;
   end
endmodule

// File: rtl/lcd_pwrsave_mgr.sv
module lcd_pwrsave_mgr #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned REG_AW    = 8,
   parameter int unsigned MEM_AW    = 6,
   parameter int unsigned GPIO_W    = 4,
   parameter int unsigned LUT_DEPTH = 16,
   parameter int unsigned PWM_DIV   = 4,
   parameter int unsigned CTRL_ADDR = 'hA0,
   parameter int unsigned GPIO_ADDR = 'hA8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_strap,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              mem_req,
   input  logic              mem_we,
   input  logic [MEM_AW-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_wdata,
   output logic              mem_ack,
   output logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] lcd_data,
   output logic              lcd_den,
   output logic              lcd_fsync,
   output logic              pwm_clk,
   output logic [GPIO_W-1:0] gpio_pins
);
   logic              ps_en, mc_asleep, gpio_role;
   logic [GPIO_W-1:0] gpio_q;
   logic [MEM_AW-1:0] scan_addr;
   logic [DATA_W-1:0] scan_data;

   lcd_pwrsave_regs #(
      .DATA_W(DATA_W), .REG_AW(REG_AW), .GPIO_W(GPIO_W), .LUT_DEPTH(LUT_DEPTH),
      .CTRL_ADDR(CTRL_ADDR), .GPIO_ADDR(GPIO_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .strap(cfg_strap), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .mc_asleep(mc_asleep),
      .reg_rdata(reg_rdata), .ps_en(ps_en), .gpio_q(gpio_q), .gpio_role(gpio_role)
   );

   lcd_pwrsave_bufctl #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_buf (
      .clk(clk), .rst_n(rst_n), .ps_en(ps_en), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .mc_asleep(mc_asleep), .scan_addr(scan_addr),
      .scan_data(scan_data)
   );

   lcd_pwrsave_panel #(
      .DATA_W(DATA_W), .MEM_AW(MEM_AW), .GPIO_W(GPIO_W), .PWM_DIV(PWM_DIV)
   ) u_panel (
      .clk(clk), .rst_n(rst_n), .ps_en(ps_en), .scan_data(scan_data),
      .scan_addr(scan_addr), .lcd_data(lcd_data), .lcd_den(lcd_den),
      .lcd_fsync(lcd_fsync), .pwm_clk(pwm_clk), .gpio_role(gpio_role),
      .gpio_q(gpio_q), .gpio_pins(gpio_pins)
   );
endmodule

// File: rtl/lcd_pwrsave_chk.sv
module lcd_pwrsave_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ps_en,
   input logic              mc_asleep,
   input logic              gpio_role,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ack,
   input logic [DATA_W-1:0] mem_rdata,
   input logic [DATA_W-1:0] lcd_data,
   input logic              lcd_den,
   input logic              pwm_clk
);
   p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ps_en && mc_asleep));

   p_wake_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ps_en && mc_asleep && mem_req && mem_we && !mem_ack) |=> !mc_asleep);

   p_sleep_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ps_en && !mc_asleep && !mem_req && !mem_ack) |=> mc_asleep);

   p_write_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && !mem_ack && !mc_asleep) |=> mem_ack);

   p_read_refused_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ps_en && mem_req && !mem_we && !mem_ack) |=> (mem_ack && mem_rdata == '0));

   p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ack |=> !mem_ack);

   p_dark_panel_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ps_en) |-> (lcd_data == '0 && !lcd_den && !pwm_clk));

   p_strap_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(gpio_role));
endmodule

bind lcd_pwrsave_mgr lcd_pwrsave_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ps_en(ps_en), .mc_asleep(mc_asleep),
   .gpio_role(gpio_role), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
   .mem_rdata(mem_rdata), .lcd_data(lcd_data), .lcd_den(lcd_den), .pwm_clk(pwm_clk)
);

// File: tb/test_lcd_pwrsave_mgr.sv
`timescale 1ns/1ps
module test_lcd_pwrsave_mgr;
   localparam int CTRL  = 'hA0;
   localparam int GPIOA = 'hA8;
   localparam int NMEM  = 64;
   localparam int NLUT  = 16;
   localparam int DIV   = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_strap = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_addr = 8'(CTRL);
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       mem_req = 1'b0;
   logic       mem_we = 1'b0;
   logic [5:0] mem_addr = '0;
   logic [7:0] mem_wdata = '0;
   logic       mem_ack;
   logic [7:0] mem_rdata;
   logic [7:0] lcd_data;
   logic       lcd_den, lcd_fsync, pwm_clk;
   logic [3:0] gpio_pins;

   always #5 clk = !clk;

   lcd_pwrsave_mgr i_lcd_pwrsave_mgr (
      .clk(clk), .rst_n(rst_n), .cfg_strap(cfg_strap), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .lcd_data(lcd_data),
      .lcd_den(lcd_den), .lcd_fsync(lcd_fsync), .pwm_clk(pwm_clk), .gpio_pins(gpio_pins)
   );

   int checks = 0, errors = 0, cycles = 0;

   // behavioural reference state
   int m_ps, m_awake, m_ack, m_rdata, m_gpio, m_role;
   int m_scan, m_ldata, m_den, m_fs, m_pwm, m_pcnt;
   int m_ram [NMEM];
   int m_lut [NLUT];

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d cycles expected below 20000", cycles);
         summary();
      end
   end

   function automatic int exp_reg();
      int a = int'(reg_addr);
      if (a == CTRL)  return m_ps | ((m_awake ? 0 : 1) << 3);
      if (a == GPIOA) return m_gpio;
      if (a < NLUT)   return m_lut[a];
      return 0;
   endfunction

   function automatic int exp_pins();
      int v = 0;
      for (int i = 0; i < 4; i++) begin
         int b;
         if (m_role != 0) b = (m_gpio >> i) & 1;
         else             b = (i % 2 == 0) ? m_den : m_fs;
         v |= b << i;
      end
      return v;
   endfunction

   task automatic model_reset(input int role);
      m_ps = 1; m_awake = 0; m_ack = 0; m_rdata = 0; m_gpio = 0; m_role = role;
      m_scan = 0; m_ldata = 0; m_den = 0; m_fs = 0; m_pwm = 0; m_pcnt = 0;
      for (int i = 0; i < NLUT; i++) m_lut[i] = 0;
   endtask

   task automatic model_step();
      int pend, a_wr, a_rd, a_no, n_awake, sd, a;
      pend = (mem_req && m_ack == 0) ? 1 : 0;
      a_wr = (pend != 0 && mem_we && m_awake != 0) ? 1 : 0;
      a_no = (pend != 0 && !mem_we && m_ps != 0) ? 1 : 0;
      a_rd = (pend != 0 && !mem_we && m_ps == 0 && m_awake != 0) ? 1 : 0;
      sd = m_ram[m_scan];
      if (m_ps == 0) n_awake = 1;
      else if (m_awake == 0 && pend != 0 && mem_we) n_awake = 1;
      else if (m_awake != 0 && !mem_req && m_ack == 0) n_awake = 0;
      else n_awake = m_awake;
      m_rdata = (a_rd != 0) ? m_ram[int'(mem_addr)] : 0;
      m_ack = (a_wr | a_rd | a_no);
      if (a_wr != 0) m_ram[int'(mem_addr)] = int'(mem_wdata);
      if (m_ps != 0) begin
         m_scan = 0; m_ldata = 0; m_den = 0; m_fs = 0; m_pwm = 0; m_pcnt = 0;
      end else begin
         m_ldata = sd; m_fs = (m_scan == 0) ? 1 : 0; m_den = 1;
         m_scan = (m_scan + 1) % NMEM;
         if (m_pcnt == DIV - 1) begin m_pcnt = 0; m_pwm = 1 - m_pwm; end
         else m_pcnt++;
      end
      m_awake = n_awake;
      if (reg_wr) begin
         a = int'(reg_addr);
         if (a == CTRL)  m_ps = int'(reg_wdata) & 1;
         if (a == GPIOA) m_gpio = int'(reg_wdata) & 15;
         if (a < NLUT)   m_lut[a] = int'(reg_wdata);
      end
   endtask

   task automatic compare_all();
      chk((int'(reg_addr) == CTRL) ? "R2 R3 control register" : "R10 register read",
          int'(reg_rdata), exp_reg());
      chk((m_ps != 0) ? "R4 ack" : "R6 ack", int'(mem_ack), m_ack);
      chk((m_ps != 0) ? "R5 read data" : "R6 read data", int'(mem_rdata), m_rdata);
      chk("R8 lcd_data", int'(lcd_data), m_ldata);
      chk("R8 lcd_fsync", int'(lcd_fsync), m_fs);
      chk("R7 lcd_den", int'(lcd_den), m_den);
      chk("R9 pwm_clk", int'(pwm_clk), m_pwm);
      chk("R11 gpio_pins", int'(gpio_pins), exp_pins());
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare_all();
   endtask

   task automatic do_reset(input logic strap);
      @(negedge clk);
      rst_n = 1'b0; cfg_strap = strap; reg_wr = 1'b0; mem_req = 1'b0;
      reg_addr = 8'(CTRL);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model_reset(int'(strap));
      compare_all();
   endtask

   task automatic reg_write(input int addr, input int data);
      reg_wr = 1'b1; reg_addr = 8'(addr); reg_wdata = 8'(data);
      tick();
      reg_wr = 1'b0; reg_addr = 8'(CTRL);
   endtask

   task automatic reg_peek(input string tag, input int addr, input int exp);
      reg_addr = 8'(addr);
      #1;
      chk(tag, int'(reg_rdata), exp);
      reg_addr = 8'(CTRL);
   endtask

   task automatic mem_op(input bit we, input int addr, input int data, input bit keep,
                         output int rd);
      int n = 0;
      mem_req = 1'b1; mem_we = we; mem_addr = 6'(addr); mem_wdata = 8'(data);
      do begin tick(); n++; end while (m_ack == 0 && n < 8);
      if (m_ack == 0) chk("R4 R6 handshake never acknowledged", 0, 1);
      rd = int'(mem_rdata);
      if (!keep) mem_req = 1'b0;
   endtask

   function automatic int pat(input int i);
      return (i * 37 + 5) & 255;
   endfunction

   initial begin
      int rd, prev, nt;
      model_reset(0);
      do_reset(1'b0);
      // R1 reset state
      chk("R1 control after reset", int'(reg_rdata), 'h09);
      chk("R1 den after reset", int'(lcd_den), 0);
      chk("R1 pwm after reset", int'(pwm_clk), 0);
      chk("R1 ack after reset", int'(mem_ack), 0);
      repeat (3) tick();

      // R10 / R11 register access in low power, panel role
      reg_write(3, 'h5A);
      reg_write(GPIOA, 'hF);
      reg_peek("R10 lut in low power", 3, 'h5A);
      reg_peek("R10 gpio reg in low power", GPIOA, 'hF);
      chk("R11 panel role pins low", int'(gpio_pins), 0);

      // R3 / R4 wake sequence on the first low-power write
      mem_req = 1'b1; mem_we = 1'b1; mem_addr = 6'd0; mem_wdata = 8'(pat(0));
      tick();
      chk("R3 status drops on wake", int'(reg_rdata[3]), 0);
      chk("R4 no ack while waking", int'(mem_ack), 0);
      tick();
      chk("R4 write acked after wake", int'(mem_ack), 1);
      mem_req = 1'b0;
      tick();
      chk("R3 status low in ack cycle", int'(reg_rdata[3]), 0);
      tick();
      chk("R3 status back to asleep", int'(reg_rdata[3]), 1);

      for (int i = 1; i < NMEM; i++) mem_op(1'b1, i, pat(i), 1'b0, rd);
      // back-to-back writes with request held high
      for (int i = 0; i < 4; i++) mem_op(1'b1, i, pat(i) ^ 'hFF, (i != 3), rd);
      repeat (2) tick();
      chk("R3 asleep after burst", int'(reg_rdata[3]), 1);

      // R5 refused read
      mem_op(1'b0, 7, 0, 1'b0, rd);
      chk("R5 refused read data", rd, 0);
      chk("R5 read does not wake", int'(reg_rdata[3]), 1);

      // leave low power; bit 3 write ignored (R2)
      reg_write(CTRL, 'h08);
      chk("R2 enable bit cleared", int'(reg_rdata[0]), 0);
      tick();
      chk("R8 first word is address 0", int'(lcd_data), pat(0) ^ 'hFF);
      chk("R8 frame sync on first word", int'(lcd_fsync), 1);
      chk("R2 status bit not writable", int'(reg_rdata), 0);
      prev = int'(pwm_clk); nt = 0;
      for (int i = 0; i < 16; i++) begin
         tick();
         if (int'(pwm_clk) != prev) nt++;
         prev = int'(pwm_clk);
      end
      chk("R9 pwm toggles in 16 cycles", nt, 16 / DIV);
      repeat (60) tick();

      // R6 normal access
      mem_op(1'b0, 5, 0, 1'b0, rd);
      chk("R6 normal read", rd, pat(5));
      mem_op(1'b1, 20, 'hC3, 1'b0, rd);
      mem_op(1'b0, 20, 0, 1'b0, rd);
      chk("R6 read after normal write", rd, 'hC3);
      repeat (3) tick();

      // R7 re-enter low power
      reg_write(CTRL, 'h01);
      tick();
      chk("R7 den low", int'(lcd_den), 0);
      chk("R7 data low", int'(lcd_data), 0);
      chk("R7 pwm stopped", int'(pwm_clk), 0);
      repeat (2) tick();
      mem_op(1'b0, 20, 0, 1'b0, rd);
      chk("R5 refused read again", rd, 0);

      // R11 GPIO role
      do_reset(1'b1);
      chk("R1 control after second reset", int'(reg_rdata), 'h09);
      reg_write(GPIOA, 'hA);
      chk("R11 gpio role drives register in low power", int'(gpio_pins), 'hA);
      reg_write(15, 'h77);
      reg_peek("R10 lut top entry", 15, 'h77);
      reg_write(CTRL, 'h00);
      repeat (10) tick();
      chk("R11 gpio role in normal mode", int'(gpio_pins), 'hA);
      reg_write(GPIOA, 'h5);
      chk("R11 gpio change in normal mode", int'(gpio_pins), 'h5);
      reg_write(2, 'h3C);
      reg_peek("R10 lut in normal mode", 2, 'h3C);
      repeat (4) tick();

      summary();
   end
endmodule